// File: doc/BRIEF.md
# Tail-Aligned Queue Entry Allocation Generator

This block turns an admitted group into the per-entry write controls of a load queue and a store queue. A one-hot handshake vector names the admitted group. The block reads that group's load count, store count and per-operation port lists from constant tables. It builds a write-enable mask and a port-index vector for each queue, padded to the queue depth. It then rotates both left around the ring by that queue's tail pointer, so that the group's first operation lands on the tail entry and later operations wrap past the last entry back to entry 0.

All outputs are registered. They appear one clock after the handshake and tail values are presented. Both queue lanes are computed in the same cycle from their own tail pointers. The handshake vector must be one-hot or all zero. A tail pointer must be below its queue's depth.

Top module: `alloc_entry_gen`

## Requirements
- R1: While `rst_ni` is low, every output is zero.
- R2: One cycle after handshake bit g is set, `ld_cnt_o` and `st_cnt_o` hold group g's load and store counts from the tables. The count outputs are as wide as the queue index.
- R3: For a group with N operations on a queue, the write-enable vector of that queue has exactly N bits set. Before rotation these are bits 0..N-1; for example, 3 loads at tail 1 in 6 entries give `001110`.
- R4: Operation k of the group (k from 0) enables entry (tail + k) mod depth. When tail + N exceeds the depth, the enables wrap to entry 0; for example, 5 loads at tail 5 in 6 entries enable entries 5, 0, 1, 2 and 3.
- R5: The port index of operation k appears in the port field of entry (tail + k) mod depth. Entry e occupies bits [e*W +: W] of the port output, where W is the port-index width. For example, load list [0,1,2] at tail 1 in 6 entries gives per-entry values [0,0,1,2,0,0].
- R6: The port field of an entry whose write enable is clear is zero, even when the table holds nonzero padding beyond the group's count.
- R7: A cycle with no handshake bit set yields all-zero enables, port indices and counts on the following cycle.
- R8: The load lane and the store lane use their own tail pointers and tables, independently, in the same cycle.
- R9: A group with zero operations on a queue asserts no enables and no port indices on that queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| grp_hs_i | input | N_GROUPS | One-hot handshake naming the admitted group, or zero |
| ld_tail_i | input | LDQ_IDX_W | Load queue tail pointer |
| st_tail_i | input | STQ_IDX_W | Store queue tail pointer |
| ld_wen_o | output | LDQ_DEPTH | Per-entry load queue write enables |
| ld_port_o | output | LDQ_DEPTH*LD_PORT_W | Per-entry load port indices, entry e at [e*LD_PORT_W +: LD_PORT_W] |
| ld_cnt_o | output | LDQ_IDX_W | Load count of the admitted group |
| st_wen_o | output | STQ_DEPTH | Per-entry store queue write enables |
| st_port_o | output | STQ_DEPTH*ST_PORT_W | Per-entry store port indices, entry e at [e*ST_PORT_W +: ST_PORT_W] |
| st_cnt_o | output | STQ_IDX_W | Store count of the admitted group |

## Verification
The load lane and the store lane both produce results in every admitted cycle, so a single handshake can wrap one queue's block of enables past its last entry while the other queue is filled without wrapping, or not filled at all. The stimulus sweeps every group against every pair of load and store tails, back to back with no idle cycles. This mixes wrapping, non-wrapping and zero-count cases across the two lanes within one cycle. A scoreboard model predicts each lane from its own tail and tables, and compares the enables, port fields and counts of both lanes field by field one cycle later. A group whose table carries nonzero padding is placed so that a padding slot would rotate onto a real entry, which shows that the padding never leaks into a port field.

// File: rtl/alloc_gen_pkg.sv
package alloc_gen_pkg;

  // index width for a ring of d entries, at least one bit
  function automatic int unsigned idx_w(int unsigned d);
    return (d > 1) ? $clog2(d) : 1;
  endfunction

  // width able to hold counts 0..d
  function automatic int unsigned cnt_w(int unsigned d);
    return $clog2(d + 1);
  endfunction

endpackage

// File: rtl/aeg_onehot_mux.sv
module aeg_onehot_mux #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0]   sel_i,
  input  logic [N*W-1:0] tbl_i,
  output logic [W-1:0]   data_o
);

  logic [W-1:0] row [N];

  for (genvar g = 0; g < N; g++) begin : g_row
    assign row[g] = tbl_i[g*W +: W] & {W{sel_i[g]}};
  end

  always_comb begin
    data_o = '0;
    for (int g = 0; g < N; g++) data_o = data_o | row[g];
  end

endmodule

// File: rtl/aeg_ring_rotl.sv
module aeg_ring_rotl #(
  parameter int unsigned D    = 6,
  parameter int unsigned W    = 1,
  parameter int unsigned SH_W = 3
) (
  input  logic [D*W-1:0] data_i,
  input  logic [SH_W-1:0] sh_i,
  output logic [D*W-1:0] data_o
);

  logic [W-1:0] ent [D];

  for (genvar e = 0; e < D; e++) begin : g_ent
    assign ent[e] = data_i[e*W +: W];
  end

  // out[j] = in[(j - sh) mod D]
  for (genvar j = 0; j < D; j++) begin : g_out
    localparam logic [SH_W:0] JJ = (SH_W+1)'(j);
    localparam logic [SH_W:0] JD = (SH_W+1)'(j + D);
    logic [SH_W:0]   sh_x;
    logic [SH_W:0]   diff;
    logic [SH_W-1:0] src;
    assign sh_x = {1'b0, sh_i};
    assign diff = (JJ >= sh_x) ? (JJ - sh_x) : (JD - sh_x);
    assign src  = diff[SH_W-1:0];
    assign data_o[j*W +: W] = ent[src];
  end

endmodule

// File: rtl/aeg_alloc_lane.sv
module aeg_alloc_lane #(
  parameter int unsigned N_GROUPS = 4,
  parameter int unsigned DEPTH    = 6,
  parameter int unsigned PORT_W   = 2,
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned IDX_W    = 3,
  parameter logic [N_GROUPS*CNT_W-1:0]        CNT_TBL  = '0,
  parameter logic [N_GROUPS*DEPTH*PORT_W-1:0] PORT_TBL = '0
) (
  input  logic [N_GROUPS-1:0]     hs_i,
  input  logic [IDX_W-1:0]        tail_i,
  output logic [DEPTH-1:0]        wen_o,
  output logic [DEPTH*PORT_W-1:0] port_o,
  output logic [CNT_W-1:0]        cnt_o
);

  localparam int unsigned ROW_W = DEPTH * PORT_W;

  logic [CNT_W-1:0]  cnt;
  logic [ROW_W-1:0]  row;
  logic [DEPTH-1:0]  raw_wen;
  logic [ROW_W-1:0]  raw_port;

  aeg_onehot_mux #(.N(N_GROUPS), .W(CNT_W)) u_cnt_lut (
    .sel_i (hs_i),
    .tbl_i (CNT_TBL),
    .data_o(cnt)
  );

  aeg_onehot_mux #(.N(N_GROUPS), .W(ROW_W)) u_port_lut (
    .sel_i (hs_i),
    .tbl_i (PORT_TBL),
    .data_o(row)
  );

  // unrotated thermometer mask; padding slots forced to zero
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    localparam logic [CNT_W-1:0] KK = CNT_W'(k);
    assign raw_wen[k]                 = KK < cnt;
    assign raw_port[k*PORT_W +: PORT_W] = raw_wen[k] ? row[k*PORT_W +: PORT_W] : '0;
  end

  aeg_ring_rotl #(.D(DEPTH), .W(1), .SH_W(IDX_W)) u_rot_wen (
    .data_i(raw_wen),
    .sh_i  (tail_i),
    .data_o(wen_o)
  );

  aeg_ring_rotl #(.D(DEPTH), .W(PORT_W), .SH_W(IDX_W)) u_rot_port (
    .data_i(raw_port),
    .sh_i  (tail_i),
    .data_o(port_o)
  );

  assign cnt_o = cnt;

endmodule

// File: rtl/alloc_entry_gen.sv
module alloc_entry_gen #(
  parameter int unsigned N_GROUPS  = 4,
  parameter int unsigned LDQ_DEPTH = 6,
  parameter int unsigned STQ_DEPTH = 4,
  parameter int unsigned LD_PORT_W = 2,
  parameter int unsigned ST_PORT_W = 2,
  parameter int unsigned LDQ_IDX_W = alloc_gen_pkg::idx_w(LDQ_DEPTH),
  parameter int unsigned STQ_IDX_W = alloc_gen_pkg::idx_w(STQ_DEPTH),
  parameter int unsigned LD_CNT_W  = alloc_gen_pkg::cnt_w(LDQ_DEPTH),
  parameter int unsigned ST_CNT_W  = alloc_gen_pkg::cnt_w(STQ_DEPTH),
  // counts, group 0 in the low field
  parameter logic [N_GROUPS*LD_CNT_W-1:0] LD_CNT_TBL = {3'd5, 3'd1, 3'd2, 3'd3},
  parameter logic [N_GROUPS*ST_CNT_W-1:0] ST_CNT_TBL = {3'd0, 3'd3, 3'd1, 3'd2},
  // port lists, group 0 in the low row, slot 0 in the low field of a row
  parameter logic [N_GROUPS*LDQ_DEPTH*LD_PORT_W-1:0] LD_PORT_TBL = {
    2'd0, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1,
    2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2,
    2'd0, 2'd0, 2'd0, 2'd3, 2'd1, 2'd3,
    2'd0, 2'd0, 2'd0, 2'd2, 2'd1, 2'd0},
  parameter logic [N_GROUPS*STQ_DEPTH*ST_PORT_W-1:0] ST_PORT_TBL = {
    2'd0, 2'd0, 2'd0, 2'd3,
    2'd0, 2'd3, 2'd1, 2'd2,
    2'd0, 2'd0, 2'd0, 2'd3,
    2'd0, 2'd0, 2'd1, 2'd0}
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_GROUPS-1:0]           grp_hs_i,
  input  logic [LDQ_IDX_W-1:0]          ld_tail_i,
  input  logic [STQ_IDX_W-1:0]          st_tail_i,
  output logic [LDQ_DEPTH-1:0]          ld_wen_o,
  output logic [LDQ_DEPTH*LD_PORT_W-1:0] ld_port_o,
  output logic [LDQ_IDX_W-1:0]          ld_cnt_o,
  output logic [STQ_DEPTH-1:0]          st_wen_o,
  output logic [STQ_DEPTH*ST_PORT_W-1:0] st_port_o,
  output logic [STQ_IDX_W-1:0]          st_cnt_o
);

  logic [LDQ_DEPTH-1:0]           ld_wen_d;
  logic [LDQ_DEPTH*LD_PORT_W-1:0] ld_port_d;
  logic [LD_CNT_W-1:0]            ld_cnt_d;
  logic [STQ_DEPTH-1:0]           st_wen_d;
  logic [STQ_DEPTH*ST_PORT_W-1:0] st_port_d;
  logic [ST_CNT_W-1:0]            st_cnt_d;

  aeg_alloc_lane #(
    .N_GROUPS(N_GROUPS), .DEPTH(LDQ_DEPTH), .PORT_W(LD_PORT_W),
    .CNT_W(LD_CNT_W), .IDX_W(LDQ_IDX_W),
    .CNT_TBL(LD_CNT_TBL), .PORT_TBL(LD_PORT_TBL)
  ) u_ld_lane (
    .hs_i  (grp_hs_i),
    .tail_i(ld_tail_i),
    .wen_o (ld_wen_d),
    .port_o(ld_port_d),
    .cnt_o (ld_cnt_d)
  );

  aeg_alloc_lane #(
    .N_GROUPS(N_GROUPS), .DEPTH(STQ_DEPTH), .PORT_W(ST_PORT_W),
    .CNT_W(ST_CNT_W), .IDX_W(STQ_IDX_W),
    .CNT_TBL(ST_CNT_TBL), .PORT_TBL(ST_PORT_TBL)
  ) u_st_lane (
    .hs_i  (grp_hs_i),
    .tail_i(st_tail_i),
    .wen_o (st_wen_d),
    .port_o(st_port_d),
    .cnt_o (st_cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_wen_o  <= '0;
      ld_port_o <= '0;
      ld_cnt_o  <= '0;
      st_wen_o  <= '0;
      st_port_o <= '0;
      st_cnt_o  <= '0;
    end else begin
      ld_wen_o  <= ld_wen_d;
      ld_port_o <= ld_port_d;
      ld_cnt_o  <= ld_cnt_d[LDQ_IDX_W-1:0];
      st_wen_o  <= st_wen_d;
      st_port_o <= st_port_d;
      st_cnt_o  <= st_cnt_d[STQ_IDX_W-1:0];
    end
  end

endmodule

// File: rtl/aeg_checker.sv
module aeg_checker #(
  parameter int unsigned N_GROUPS  = 4,
  parameter int unsigned LDQ_DEPTH = 6,
  parameter int unsigned STQ_DEPTH = 4,
  parameter int unsigned LD_PORT_W = 2,
  parameter int unsigned ST_PORT_W = 2,
  parameter int unsigned LDQ_IDX_W = 3,
  parameter int unsigned STQ_IDX_W = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [N_GROUPS-1:0]            grp_hs_i,
  input logic [LDQ_IDX_W-1:0]           ld_tail_i,
  input logic [STQ_IDX_W-1:0]           st_tail_i,
  input logic [LDQ_DEPTH-1:0]           ld_wen_o,
  input logic [LDQ_DEPTH*LD_PORT_W-1:0] ld_port_o,
  input logic [LDQ_IDX_W-1:0]           ld_cnt_o,
  input logic [STQ_DEPTH-1:0]           st_wen_o,
  input logic [STQ_DEPTH*ST_PORT_W-1:0] st_port_o,
  input logic [STQ_IDX_W-1:0]           st_cnt_o
);

  logic [LDQ_DEPTH*LD_PORT_W-1:0] ld_wen_x;
  logic [STQ_DEPTH*ST_PORT_W-1:0] st_wen_x;

  for (genvar e = 0; e < LDQ_DEPTH; e++) begin : g_ldx
    assign ld_wen_x[e*LD_PORT_W +: LD_PORT_W] = {LD_PORT_W{ld_wen_o[e]}};
  end
  for (genvar e = 0; e < STQ_DEPTH; e++) begin : g_stx
    assign st_wen_x[e*ST_PORT_W +: ST_PORT_W] = {ST_PORT_W{st_wen_o[e]}};
  end

  AST_HS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grp_hs_i)); // R2

  AST_TAIL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(ld_tail_i) < LDQ_DEPTH) && (32'(st_tail_i) < STQ_DEPTH)); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|grp_hs_i) |=> (ld_wen_o == '0 && st_wen_o == '0 && ld_port_o == '0 &&
                      st_port_o == '0 && ld_cnt_o == '0 && st_cnt_o == '0)); // R7

  AST_LD_CNT_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_cnt_o == LDQ_IDX_W'($countones(ld_wen_o))); // R3

  AST_ST_CNT_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_cnt_o == STQ_IDX_W'($countones(st_wen_o))); // R3

  AST_LD_TAIL_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_cnt_o != '0) |-> ld_wen_o[$past(ld_tail_i)]); // R4

  AST_ST_TAIL_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_cnt_o != '0) |-> st_wen_o[$past(st_tail_i)]); // R4

  AST_LD_PORT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_port_o & ~ld_wen_x) == '0); // R6

  AST_ST_PORT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_port_o & ~st_wen_x) == '0); // R6

endmodule

bind alloc_entry_gen aeg_checker #(
  .N_GROUPS(N_GROUPS), .LDQ_DEPTH(LDQ_DEPTH), .STQ_DEPTH(STQ_DEPTH),
  .LD_PORT_W(LD_PORT_W), .ST_PORT_W(ST_PORT_W),
  .LDQ_IDX_W(LDQ_IDX_W), .STQ_IDX_W(STQ_IDX_W)
) u_chk (.*);

// File: tb/alloc_entry_gen_tb.sv
`timescale 1ns/1ps
module alloc_entry_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hs = '0;
  logic [2:0]  ld_tail = '0;
  logic [1:0]  st_tail = '0;
  logic [5:0]  ld_wen;
  logic [11:0] ld_port;
  logic [2:0]  ld_cnt;
  logic [3:0]  st_wen;
  logic [7:0]  st_port;
  logic [1:0]  st_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit timed_out = 1'b0;

  always #2.5 clk = ~clk;

  alloc_entry_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .grp_hs_i(hs),
    .ld_tail_i(ld_tail), .st_tail_i(st_tail),
    .ld_wen_o(ld_wen), .ld_port_o(ld_port), .ld_cnt_o(ld_cnt),
    .st_wen_o(st_wen), .st_port_o(st_port), .st_cnt_o(st_cnt)
  );

  // model tables (padding zero by definition)
  int ld_cnt_m [4] = '{3, 2, 1, 5};
  int st_cnt_m [4] = '{2, 1, 3, 0};
  int ld_port_m [4][6] = '{'{0,1,2,0,0,0}, '{3,1,0,0,0,0}, '{2,0,0,0,0,0}, '{1,2,3,0,1,0}};
  int st_port_m [4][4] = '{'{0,1,0,0}, '{3,0,0,0}, '{2,1,3,0}, '{0,0,0,0}};

  typedef struct {
    logic [5:0]  ld_wen;
    logic [11:0] ld_port;
    logic [2:0]  ld_cnt;
    logic [3:0]  st_wen;
    logic [7:0]  st_port;
    logic [1:0]  st_cnt;
    string       tag;
  } exp_t;

  exp_t sb [$];

  task automatic chk(bit ok, string req, string ctx, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) act=%h exp=%h", req, ctx, act, exp);
    end
  endtask

  task automatic drive(int g, int lt, int stl, string tag);
    exp_t e;
    @(negedge clk);
    hs      = (g < 0) ? 4'd0 : 4'(1 << g);
    ld_tail = 3'(lt);
    st_tail = 2'(stl);
    e.ld_wen = '0; e.ld_port = '0; e.st_wen = '0; e.st_port = '0;
    e.ld_cnt = (g < 0) ? 3'd0 : 3'(ld_cnt_m[g]);
    e.st_cnt = (g < 0) ? 2'd0 : 2'(st_cnt_m[g]);
    e.tag    = tag;
    if (g >= 0) begin
      for (int q = 0; q < 6; q++) begin
        int k = (q - lt + 6) % 6;
        if (k < ld_cnt_m[g]) begin
          e.ld_wen[q] = 1'b1;
          e.ld_port[q*2 +: 2] = 2'(ld_port_m[g][k]);
        end
      end
      for (int q = 0; q < 4; q++) begin
        int k = (q - stl + 4) % 4;
        if (k < st_cnt_m[g]) begin
          e.st_wen[q] = 1'b1;
          e.st_port[q*2 +: 2] = 2'(st_port_m[g][k]);
        end
      end
    end
    sb.push_back(e);
  endtask

  task automatic monitor();
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e = sb.pop_front();
        chk(ld_cnt == e.ld_cnt,   "R2", {e.tag, " ld_cnt"},  32'(ld_cnt),  32'(e.ld_cnt));
        chk(st_cnt == e.st_cnt,   "R2", {e.tag, " st_cnt"},  32'(st_cnt),  32'(e.st_cnt));
        chk(ld_wen == e.ld_wen,   "R3", {e.tag, " ld_wen"},  32'(ld_wen),  32'(e.ld_wen));
        chk(st_wen == e.st_wen,   "R3", {e.tag, " st_wen"},  32'(st_wen),  32'(e.st_wen));
        chk(ld_port == e.ld_port, "R5", {e.tag, " ld_port"}, 32'(ld_port), 32'(e.ld_port));
        chk(st_port == e.st_port, "R5", {e.tag, " st_port"}, 32'(st_port), 32'(e.st_port));
      end
    end
  endtask

  task automatic run();
    // R1: inputs active during reset, outputs stay zero
    hs = 4'b0001; ld_tail = 3'd1; st_tail = 2'd1;
    repeat (3) @(negedge clk);
    chk({ld_wen, ld_port, ld_cnt, st_wen, st_port, st_cnt} == '0, "R1", "reset",
        32'({ld_wen, st_wen}), 32'd0);
    hs = '0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, 1, 1, "R3 R5 example");
    drive(-1, 2, 3, "R7 idle");
    drive(3, 5, 2, "R4 R8 R9 load wrap, no stores");
    drive(1, 4, 3, "R6 R4 padding at entry 0");
    drive(2, 0, 2, "R4 R8 store wrap");
    drive(-1, 5, 1, "R7 idle after wrap");
    for (int g = 0; g < 4; g++)
      for (int lt = 0; lt < 6; lt++)
        for (int s = 0; s < 4; s++)
          drive(g, lt, s, "R8 sweep");
    drive(-1, 0, 0, "R7 idle end");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      monitor();
    join_none
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule